// File: doc/BRIEF.md
# Power-Fail Guarded SRAM Bank Select

This block drives the active-low chip enables of two external static RAM banks. An external enable and a bank-select bit choose which bank is enabled while the supply is healthy. The same block also gates the strobes for a small local register file. Two digital power indications are inputs. The first, `pwr_ok`, says that the supply is above the deselect threshold. The second, `bat_mode`, says that the part has switched to its backup source.

When either indication reports a fault, every bank enable and every register strobe goes inactive at the next clock edge. This cuts off any access already in progress. Release after power returns is slow on purpose. The good-power indication first passes through a synchronizer, then a programmable hold-off counter must expire. After that the block waits for a moment when no access is requested, so that a half-started cycle can never reach the RAM. All outputs are registered, so they do not glitch when the enable and the bank bit change together.

Top module: `sram_bank_guard`

## Requirements
- R1: With power released, `ext_en_n` low and `bank_sel` 0 sampled at a clock edge, `ram_ce_n` becomes 2'b10 (bit 0 low selects bank 0) after that edge.
- R2: With power released, `ext_en_n` low and `bank_sel` 1, `ram_ce_n` becomes 2'b01 after that edge.
- R3: With `ext_en_n` high, `ram_ce_n` is 2'b11 after the edge, whatever `bank_sel` is.
- R4: When `pwr_ok` is low at an edge, `ram_ce_n` is 2'b11 after that edge, whatever `ext_en_n` and `bank_sel` are, even if an access was active.
- R5: When `bat_mode` is high at an edge, `ram_ce_n` is 2'b11 after that edge, even with `pwr_ok` high.
- R6: Take edge 1 as the first edge with good power (`pwr_ok` high, `bat_mode` low) after a fault or reset, with power good from then on. With `SYNC_STAGES` = S and `HOLD_CYCLES` = H, release happens at edge S+H+1, provided `ext_en_n` is high there. An access sampled at edge S+H+2 is then the earliest that can drive a bank enable.
- R7: Release is only taken at an edge where `ext_en_n` is high. While `ext_en_n` stays low, the outputs stay 2'b11 however long power has been good.
- R8: A fault during the hold-off restarts the full delay of R6 from the next good edge.
- R9: With power released, `reg_rd_stb` follows (`chip_en_n` low, `rd_en_n` low and `wr_en_n` high), and `reg_wr_stb` follows (`chip_en_n` low and `wr_en_n` low). Both change one edge after sampling. With `chip_en_n` high, both strobes are 0.
- R10: During a fault, `reg_wr_stb` and `reg_rd_stb` are 0 after the edge.
- R11: While `rst_n` is low, `ram_ce_n` is 2'b11 and both strobes are 0. After reset, release follows R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | High when supply is above the deselect threshold |
| bat_mode | input | 1 | High when running from the backup source |
| ext_en_n | input | 1 | Active-low external RAM enable request |
| bank_sel | input | SEL_W | Bank-select address bit(s) |
| chip_en_n | input | 1 | Active-low enable for local register access |
| rd_en_n | input | 1 | Active-low output enable for register reads |
| wr_en_n | input | 1 | Active-low write enable |
| ram_ce_n | output | 2**SEL_W | Active-low bank enables, bit n for bank n |
| reg_rd_stb | output | 1 | Registered register-read strobe (data bus driven) |
| reg_wr_stb | output | 1 | Registered register-write strobe |

## Verification
A release flag that is wrong in the permissive direction shows at `ram_ce_n` one edge later. In that case a bank enables during the hold-off, or while the enable was held low across the release point. If the hold-off counter runs off by one, the first legal access appears one edge early or late against the count in R6. If the synchronizer is not cleared on a fault, the restart in R8 comes out two edges short. A release flag stuck low leaves every bank dark after power returns. A decode fault swaps or merges the two bank enables on the very next edge.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
  } reg_stb_t;

  // a bank or register access may pass only when released and not failing
  function automatic logic access_ok(input logic released,
                                     input logic fault,
                                     input logic en_n);
    return released & ~fault & ~en_n;
  endfunction

  // register strobes: write wins over read
  function automatic reg_stb_t reg_strobes(input logic go,
                                           input logic rd_n,
                                           input logic wr_n);
    reg_stb_t s;
    s.wr = go & ~wr_n;
    s.rd = go & ~rd_n & wr_n;
    return s;
  endfunction

  function automatic int count_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 2);
  endfunction

endpackage

// File: rtl/sbg_sync.sv
module sbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clear) begin
      q <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) q[i] <= q[i-1];
      q[0] <= din;
    end
  end

  assign dout = q[STAGES-1];

  // a clear must leave the chain empty on the next edge (R8)
  p_sync_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == '0));

endmodule

// File: rtl/sbg_release.sv
module sbg_release #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic good_sync,
  input  logic idle,
  output logic released
);
  localparam int CW = sbg_pkg::count_width(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;
  logic          hold_done;
  logic          take_release;

  assign hold_done    = (cnt == HOLD_V);
  assign take_release = hold_done & good_sync & idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (fault) begin
      cnt      <= '0;
      released <= 1'b0;
    end else begin
      if (good_sync && !hold_done) cnt <= cnt + 1'b1;
      if (take_release)            released <= 1'b1;
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= HOLD_V);

  p_release_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(hold_done));

  p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(idle));

  p_fault_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !released);

endmodule

// File: rtl/sbg_decode.sv
module sbg_decode #(
  parameter int SEL_W = 1,
  localparam int NB   = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             released,
  input  logic             fault,
  input  logic             ext_en_n,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic             chip_en_n,
  input  logic             rd_en_n,
  input  logic             wr_en_n,
  output logic [NB-1:0]    ram_ce_n,
  output logic             reg_rd_stb,
  output logic             reg_wr_stb
);
  import sbg_pkg::*;

  logic     ram_go;
  logic     reg_go;
  reg_stb_t stb_next;

  assign ram_go   = access_ok(released, fault, ext_en_n);
  assign reg_go   = access_ok(released, fault, chip_en_n);
  assign stb_next = reg_strobes(reg_go, rd_en_n, wr_en_n);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ram_ce_n[b] <= 1'b1;
      else        ram_ce_n[b] <= ~(ram_go && (bank_sel == SEL_W'(b)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rd_stb <= 1'b0;
      reg_wr_stb <= 1'b0;
    end else begin
      reg_rd_stb <= stb_next.rd;
      reg_wr_stb <= stb_next.wr;
    end
  end

  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ram_ce_n));

  p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en_n |=> (ram_ce_n == '1));

  p_fault_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (ram_ce_n == '1));

  p_write_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!reg_wr_stb && !reg_rd_stb));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_stb && reg_wr_stb));

endmodule

// File: rtl/sram_bank_guard.sv
module sram_bank_guard #(
  parameter int SEL_W       = 1,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8,
  localparam int NB         = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             bat_mode,
  input  logic             ext_en_n,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic             chip_en_n,
  input  logic             rd_en_n,
  input  logic             wr_en_n,
  output logic [NB-1:0]    ram_ce_n,
  output logic             reg_rd_stb,
  output logic             reg_wr_stb
);
  logic fault_now;
  logic good_sync;
  logic released;

  assign fault_now = ~pwr_ok | bat_mode;

  sbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fault_now),
    .din   (1'b1),
    .dout  (good_sync)
  );

  sbg_release #(.HOLD_CYCLES(HOLD_CYCLES)) u_release (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault     (fault_now),
    .good_sync (good_sync),
    .idle      (ext_en_n),
    .released  (released)
  );

  sbg_decode #(.SEL_W(SEL_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .released   (released),
    .fault      (fault_now),
    .ext_en_n   (ext_en_n),
    .bank_sel   (bank_sel),
    .chip_en_n  (chip_en_n),
    .rd_en_n    (rd_en_n),
    .wr_en_n    (wr_en_n),
    .ram_ce_n   (ram_ce_n),
    .reg_rd_stb (reg_rd_stb),
    .reg_wr_stb (reg_wr_stb)
  );

  p_battery_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bat_mode |=> (ram_ce_n == '1));

endmodule

// File: tb/sram_bank_guard_bench.sv
`timescale 1ns/1ps
module sram_bank_guard_bench;
  localparam int S = 2;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1, bat_mode = 1'b0;
  logic ext_en_n = 1'b1, chip_en_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
  logic [0:0] bank_sel = 1'b0;
  logic [1:0] ram_ce_n;
  logic reg_rd_stb, reg_wr_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_bank_guard #(.SEL_W(1), .SYNC_STAGES(S), .HOLD_CYCLES(H)) u_sram_bank_guard (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bat_mode(bat_mode),
    .ext_en_n(ext_en_n), .bank_sel(bank_sel), .chip_en_n(chip_en_n),
    .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .ram_ce_n(ram_ce_n),
    .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb));

  // expected {ram_ce_n[1], ram_ce_n[0], rd, wr}
  function automatic logic [3:0] expect_out(input logic rel, input logic ex_n,
      input logic a, input logic ce_n, input logic rd_n, input logic wr_n);
    logic [1:0] ce;
    logic r, w;
    ce = 2'b11;
    if (rel && !ex_n) ce[a] = 1'b0;
    w = rel && !ce_n && !wr_n;
    r = rel && !ce_n && !rd_n && wr_n;
    return {ce, r, w};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ram_ce_n, reg_rd_stb, reg_wr_stb};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R11: reset state, even with an access requested
    ext_en_n = 1'b0; chip_en_n = 1'b0; wr_en_n = 1'b0;
    repeat (3) step();
    check("R11", 4'b1100);
    ext_en_n = 1'b1; chip_en_n = 1'b1; wr_en_n = 1'b1;
    step();
    rst_n = 1'b1;

    // R6: release at edge S+H+1, first access at edge S+H+2
    for (int e = 1; e <= S + H + 1; e++) begin
      step();
      check("R6 R11 hold", 4'b1100);
    end
    ext_en_n = 1'b0; bank_sel = 1'b0;
    step();
    check("R6 first access", 4'b1000);

    // R1 R2 R3 R9: full sweep while released
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      b = 5'(v);
      {ext_en_n, bank_sel[0], chip_en_n, rd_en_n, wr_en_n} = b;
      step();
      check("R1 R2 R3 R9 sweep",
            expect_out(1'b1, b[4], b[3], b[2], b[1], b[0]));
    end

    // R4 R10: supply fault cuts an active access
    ext_en_n = 1'b0; bank_sel = 1'b1; chip_en_n = 1'b0; rd_en_n = 1'b1; wr_en_n = 1'b0;
    step();
    check("R2 R9 before fault", 4'b0101);
    pwr_ok = 1'b0;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] b;
      b = 4'(v);
      {ext_en_n, bank_sel[0], chip_en_n, wr_en_n} = b;
      rd_en_n = 1'b0;
      step();
      check("R4 R10 fault", 4'b1100);
    end

    // R7: power back, enable held low, no release
    pwr_ok = 1'b1; ext_en_n = 1'b0; bank_sel = 1'b0; chip_en_n = 1'b1;
    rd_en_n = 1'b1; wr_en_n = 1'b1;
    for (int e = 0; e < S + H + 6; e++) begin
      step();
      check("R7 busy blocks release", 4'b1100);
    end
    ext_en_n = 1'b1;
    step();
    check("R7 idle edge", 4'b1100);
    ext_en_n = 1'b0;
    step();
    check("R7 access after idle", 4'b1000);

    // R5: backup mode deselects with pwr_ok still high
    bank_sel = 1'b1; chip_en_n = 1'b0; wr_en_n = 1'b0;
    step();
    check("R5 before backup", 4'b0101);
    bat_mode = 1'b1;
    for (int v = 0; v < 4; v++) begin
      {ext_en_n, bank_sel[0]} = 2'(v);
      step();
      check("R5 backup", 4'b1100);
    end

    // R8: fault in mid hold-off restarts the whole delay
    bat_mode = 1'b0; ext_en_n = 1'b1; chip_en_n = 1'b1; wr_en_n = 1'b1;
    repeat (H) step();
    pwr_ok = 1'b0;
    step();
    check("R8 glitch", 4'b1100);
    pwr_ok = 1'b1;
    for (int e = 1; e <= S + H; e++) begin
      step();
      check("R8 hold", 4'b1100);
    end
    ext_en_n = 1'b0; bank_sel = 1'b1;
    step();
    check("R8 R6 not early", 4'b1100);
    ext_en_n = 1'b1;
    step();
    ext_en_n = 1'b0;
    step();
    check("R8 late release", 4'b0100);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule